// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a bank of clocked monostable pulse generators. Each channel produces a single high pulse on its output `q` whose length is a programmed number of clock cycles, together with the complement `qN`. A pulse is started by either of two trigger inputs. One input fires on its rising edge, but only while the other input is high. The other input fires on its falling edge, but only while the first input is low. So each trigger input also acts as an enable for the other.

Every channel has its own active-low clear, which forces the output idle and blocks triggers. It also has its own mode bit. In retriggerable mode a valid trigger during a pulse restarts the full width. In non-retriggerable mode such a trigger is ignored. All three control inputs of a channel pass through a two-flop synchroniser, and edges are detected against the previous synchronised sample. The inputs may therefore be asynchronous to `clk`.

A channel's width is read when a trigger is accepted. Software-free use is intended: the width and mode are static configuration that is changed while the channel is idle.

Top module: `oneShotBank`

## Requirements
- R1: A rising edge on `trigRise[i]` while `trigFall[i]` is high starts a pulse. If the rise is first sampled by clock edge E0, `q[i]` is high after clock edge E0+2 and stays high for exactly N cycles, where N is the channel's `pulseWidth` slice.
- R2: A falling edge on `trigFall[i]` while `trigRise[i]` is low starts a pulse with the same latency and width as R1.
- R3: While `clrN[i]` is low, `q[i]` is low from the second clock edge that samples the low level onward, and no trigger edge is accepted.
- R4: When `retrigMode[i]` is 1 (retriggerable), an accepted trigger during a pulse reloads N. The pulse then ends N cycles after the load of the last trigger.
- R5: When `retrigMode[i]` is 0 (non-retriggerable), triggers seen while the pulse is active are ignored, so the pulse lasts exactly N cycles from the first trigger.
- R6: During and right after the system reset `rstN` (active low), every `q` is 0 and every `qN` is 1.
- R7: `qN[i]` is always the inverse of `q[i]`.
- R8: Edges that fail their qualification produce no pulse. These are a rise of `trigRise` while `trigFall` is low, a fall of `trigFall` while `trigRise` is high, a fall of `trigRise`, and a rise of `trigFall`.
- R9: Releasing `clrN[i]` while the inputs already hold a qualifying level combination produces no pulse. Only a new edge after the release does.
- R10: A trigger accepted while N = 0 produces no pulse.
- R11: Channels are independent. Activity on one channel's inputs never changes another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| trigRise | input | NUM_CH | Per channel: rising-edge trigger, qualifies falling triggers when low |
| trigFall | input | NUM_CH | Per channel: falling-edge trigger, qualifies rising triggers when high |
| clrN | input | NUM_CH | Per channel clear, active low |
| retrigMode | input | NUM_CH | Per channel: 1 retriggerable, 0 non-retriggerable |
| pulseWidth | input | NUM_CH*WIDTH | Per channel pulse width N in cycles; channel i uses bits [i*WIDTH +: WIDTH] |
| q | output | NUM_CH | Per channel pulse output |
| qN | output | NUM_CH | Per channel complement of q |

## Verification
The bench targets the following corner cases, each of which would make a faulty design visibly wrong:
- Exact latency and width. An off-by-one counter stretches or trims the pulse by a cycle.
- A second trigger during a pulse. This separates the two modes: a mode mix-up gives a 9-cycle pulse where 5 are expected, or the reverse.
- Unqualified edges and edges during clear. A missing qualification, or a clear that does not block triggers, produces a spurious pulse.
- Clear release over already-qualifying levels. A level-sensitive trigger would fire on release.
- N = 0 and cross-channel activity. A zero width that wraps, or a shared signal between channels, appears as an unexpected high cycle.

A cycle-level random run against a model built from these rules covers the orderings that the directed cases do not reach.

// File: rtl/osPkg.sv
package osPkg;
  // synchroniser depth for every asynchronous control input
  localparam int SYNC_STAGES = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // start or restart the width counter
    logic hold;   // clear active: force counter and output idle
  } osStrobe_t;
endpackage

// File: rtl/osSync.sv
module osSync #(
  parameter int STAGES = osPkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : gMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/osControl.sv
module osControl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigRise,
  input  logic             trigFall,
  input  logic             clrN,
  input  logic             retrigMode,
  input  logic [WIDTH-1:0] width,
  input  logic             busy,
  output osPkg::osStrobe_t strobe
);
  logic riseSync, fallSync, clrSync;
  logic risePrev, fallPrev, clrPrev;
  logic riseQual, fallQual, clearOpen, accept;

  osSync uRiseSync (.clk(clk), .rstN(rstN), .din(trigRise), .dout(riseSync));
  osSync uFallSync (.clk(clk), .rstN(rstN), .din(trigFall), .dout(fallSync));
  osSync uClrSync  (.clk(clk), .rstN(rstN), .din(clrN),     .dout(clrSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      risePrev <= 1'b0;
      fallPrev <= 1'b0;
      clrPrev  <= 1'b0;
    end else begin
      risePrev <= riseSync;
      fallPrev <= fallSync;
      clrPrev  <= clrSync;
    end
  end

  always_comb begin
    riseQual  = riseSync & ~risePrev & fallSync;
    fallQual  = ~fallSync & fallPrev & ~riseSync;
    // clear must have been seen released for a full cycle
    clearOpen = clrSync & clrPrev;
    accept    = clearOpen & (riseQual | fallQual) & (|width) & (retrigMode | ~busy);
    strobe.load = accept;
    strobe.hold = ~clrSync;
  end
endmodule

// File: rtl/osDatapath.sv
module osDatapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  osPkg::osStrobe_t strobe,
  input  logic [WIDTH-1:0] width,
  output logic             busy,
  output logic             q,
  output logic             qN
);
  logic [WIDTH-1:0] remaining;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                remaining <= '0;
    else if (strobe.load)     remaining <= width;
    else if (strobe.hold)     remaining <= '0;
    else if (remaining != '0) remaining <= remaining - 1'b1;
  end

  assign busy = (remaining != '0);
  assign q    = busy & ~strobe.hold;
  assign qN   = ~q;
endmodule

// File: rtl/oneShotBank.sv
module oneShotBank #(
  parameter int NUM_CH = 2,
  parameter int WIDTH  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       trigRise,
  input  logic [NUM_CH-1:0]       trigFall,
  input  logic [NUM_CH-1:0]       clrN,
  input  logic [NUM_CH-1:0]       retrigMode,
  input  logic [NUM_CH*WIDTH-1:0] pulseWidth,
  output logic [NUM_CH-1:0]       q,
  output logic [NUM_CH-1:0]       qN
);
  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : gCh
      osPkg::osStrobe_t strobe;
      logic             busy;
      logic [WIDTH-1:0] chWidth;

      assign chWidth = pulseWidth[ch*WIDTH +: WIDTH];

      osControl #(.WIDTH(WIDTH)) uCtrl (
        .clk(clk), .rstN(rstN),
        .trigRise(trigRise[ch]), .trigFall(trigFall[ch]),
        .clrN(clrN[ch]), .retrigMode(retrigMode[ch]),
        .width(chWidth), .busy(busy), .strobe(strobe)
      );

      osDatapath #(.WIDTH(WIDTH)) uData (
        .clk(clk), .rstN(rstN), .strobe(strobe), .width(chWidth),
        .busy(busy), .q(q[ch]), .qN(qN[ch])
      );
    end
  endgenerate
endmodule

// File: rtl/osChecker.sv
module osChecker #(
  parameter int NUM_CH = 2,
  parameter int WIDTH  = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_CH-1:0]       trigRise,
  input logic [NUM_CH-1:0]       trigFall,
  input logic [NUM_CH-1:0]       clrN,
  input logic [NUM_CH-1:0]       retrigMode,
  input logic [NUM_CH*WIDTH-1:0] pulseWidth,
  input logic [NUM_CH-1:0]       q,
  input logic [NUM_CH-1:0]       qN
);
  localparam int RUNW = WIDTH + 1;

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : gChk
      logic [RUNW-1:0] runLen;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                runLen <= '0;
        else if (!q[i])           runLen <= '0;
        else if (runLen != '1)    runLen <= runLen + 1'b1;
      end

      // R3
      clear_forces_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
        !$past(clrN[i], 2) |-> !q[i]);

      // R1 R2 R8
      qualified_start_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(q[i]) |->
          (($past(trigRise[i], 3) && !$past(trigRise[i], 4) && $past(trigFall[i], 3)) ||
           (!$past(trigFall[i], 3) && $past(trigFall[i], 4) && !$past(trigRise[i], 3))));

      // R5
      nonretrig_width_chk: assert property (@(posedge clk) disable iff (!rstN)
        (q[i] && !retrigMode[i]) |-> (runLen < RUNW'(pulseWidth[i*WIDTH +: WIDTH])));

      // R10
      zero_width_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(q[i]) |-> ($past(pulseWidth[i*WIDTH +: WIDTH]) != '0));
    end
  endgenerate
endmodule

bind oneShotBank osChecker #(.NUM_CH(NUM_CH), .WIDTH(WIDTH)) uChk (
  .clk(clk), .rstN(rstN), .trigRise(trigRise), .trigFall(trigFall),
  .clrN(clrN), .retrigMode(retrigMode), .pulseWidth(pulseWidth),
  .q(q), .qN(qN)
);

// File: tb/sim_oneShotBank.sv
`timescale 1ns/1ps
module sim_oneShotBank;
  localparam int NCH = 2;
  localparam int W   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0]   trigRise = '0, trigFall = '1, clrN = '1, retrigMode = '1;
  logic [NCH*W-1:0] pulseWidth = '0;
  logic [NCH-1:0]   q, qN;

  int checks = 0, errors = 0;
  int hiCnt [NCH];
  bit done = 0;
  bit modelOn = 0;

  always #2.5 clk = ~clk;

  oneShotBank #(.NUM_CH(NCH), .WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .trigRise(trigRise), .trigFall(trigFall),
    .clrN(clrN), .retrigMode(retrigMode), .pulseWidth(pulseWidth),
    .q(q), .qN(qN)
  );

  // cycle-level reference built from the requirements
  bit mS1a[NCH], mS2a[NCH], mPa[NCH], mS1b[NCH], mS2b[NCH], mPb[NCH];
  bit mS1r[NCH], mS2r[NCH], mPr[NCH];
  int mCnt[NCH];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        mS1a[c] = 0; mS2a[c] = 0; mPa[c] = 0; mS1b[c] = 0; mS2b[c] = 0; mPb[c] = 0;
        mS1r[c] = 0; mS2r[c] = 0; mPr[c] = 0; mCnt[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit rq, fq, acc;
        int w;
        w   = int'(pulseWidth[c*W +: W]);
        rq  = mS2a[c] && !mPa[c] && mS2b[c];
        fq  = !mS2b[c] && mPb[c] && !mS2a[c];
        acc = mS2r[c] && mPr[c] && (rq || fq) && (w != 0) && (retrigMode[c] || mCnt[c] == 0);
        if (acc)            mCnt[c] = w;
        else if (!mS2r[c])  mCnt[c] = 0;
        else if (mCnt[c] != 0) mCnt[c] = mCnt[c] - 1;
        mPa[c] = mS2a[c]; mS2a[c] = mS1a[c]; mS1a[c] = trigRise[c];
        mPb[c] = mS2b[c]; mS2b[c] = mS1b[c]; mS1b[c] = trigFall[c];
        mPr[c] = mS2r[c]; mS2r[c] = mS1r[c]; mS1r[c] = clrN[c];
      end
    end
  end

  function automatic bit expQ(int c);
    return (mCnt[c] != 0) && mS2r[c];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // every negedge: model compare, complement check, high-cycle counting
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int c = 0; c < NCH; c++) begin
        if (q[c]) hiCnt[c]++;
        chk(qN[c] == ~q[c], "R7 qN inverse", int'(qN[c]), int'(~q[c]));
        if (modelOn) chk(q[c] == expQ(c), "R1/R2/R4/R5 model", int'(q[c]), int'(expQ(c)));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clrCounts();
    for (int c = 0; c < NCH; c++) hiCnt[c] = 0;
  endtask

  task automatic setW(int c, int w);
    pulseWidth[c*W +: W] = W'(w);
  endtask

  task automatic summary();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4538));
    setW(0, 5); setW(1, 7);
    step(3);
    chk(q == '0, "R6 reset q", int'(q), 0);
    chk(qN == '1, "R6 reset qN", int'(qN), 3);
    rstN = 1'b1;
    step(1);
    chk(q == '0, "R6 after reset q", int'(q), 0);
    modelOn = 1;
    step(6);

    // R1: latency and width
    clrCounts();
    trigRise[0] = 1'b1;
    step(2);
    chk(q[0] == 1'b0, "R1 before latency", int'(q[0]), 0);
    step(1);
    chk(q[0] == 1'b1, "R1 first high", int'(q[0]), 1);
    step(20);
    chk(hiCnt[0] == 5, "R1 width", hiCnt[0], 5);

    // R8: falling trigRise does nothing
    clrCounts();
    trigRise[0] = 1'b0;
    step(10);
    chk(hiCnt[0] == 0, "R8 fall of rise input", hiCnt[0], 0);

    // R2: falling trigFall with trigRise low
    clrCounts();
    trigFall[0] = 1'b0;
    step(20);
    chk(hiCnt[0] == 5, "R2 width", hiCnt[0], 5);

    // R8: unqualified edges
    clrCounts();
    trigRise[0] = 1'b1; step(6);   // rise with fall input low
    trigFall[0] = 1'b1; step(6);   // rise of fall input
    trigFall[0] = 1'b0; step(6);   // fall with rise input high
    trigRise[0] = 1'b0; step(6);
    trigFall[0] = 1'b1; step(10);
    chk(hiCnt[0] == 0, "R8 unqualified edges", hiCnt[0], 0);

    // R4: retriggerable, second trigger 4 cycles after first
    clrCounts();
    retrigMode[0] = 1'b1;
    trigRise[0] = 1'b1; step(2);
    trigRise[0] = 1'b0; step(2);
    trigRise[0] = 1'b1; step(30);
    chk(hiCnt[0] == 9, "R4 extended pulse", hiCnt[0], 9);
    trigRise[0] = 1'b0; step(6);

    // R5: non-retriggerable, same stimulus
    clrCounts();
    retrigMode[0] = 1'b0;
    trigRise[0] = 1'b1; step(2);
    trigRise[0] = 1'b0; step(2);
    trigRise[0] = 1'b1; step(30);
    chk(hiCnt[0] == 5, "R5 ignored retrigger", hiCnt[0], 5);
    trigRise[0] = 1'b0; step(6);
    clrCounts();
    trigRise[0] = 1'b1; step(20);
    chk(hiCnt[0] == 5, "R5 new pulse after end", hiCnt[0], 5);
    trigRise[0] = 1'b0; step(6);
    retrigMode[0] = 1'b1;

    // R3: clear cuts a pulse and blocks triggers
    setW(0, 20);
    step(2);
    trigRise[0] = 1'b1; step(5);
    clrN[0] = 1'b0; step(1);
    chk(q[0] == 1'b1, "R3 one cycle after clear", int'(q[0]), 1);
    step(1);
    chk(q[0] == 1'b0, "R3 forced low", int'(q[0]), 0);
    clrCounts();
    trigRise[0] = 1'b0; step(3);
    trigRise[0] = 1'b1; step(8);
    chk(hiCnt[0] == 0, "R3 trigger during clear", hiCnt[0], 0);

    // R9: release with qualifying levels present
    clrN[0] = 1'b1; step(12);
    chk(hiCnt[0] == 0, "R9 release no pulse", hiCnt[0], 0);
    trigRise[0] = 1'b0; step(4);
    trigRise[0] = 1'b1; step(30);
    chk(hiCnt[0] == 20, "R9 edge after release", hiCnt[0], 20);
    trigRise[0] = 1'b0; step(4);

    // R10: zero width
    clrCounts();
    setW(0, 0); step(2);
    trigRise[0] = 1'b1; step(12);
    chk(hiCnt[0] == 0, "R10 zero width", hiCnt[0], 0);
    trigRise[0] = 1'b0; step(4);

    // R11: channel 1 untouched so far, then both together
    chk(hiCnt[1] == 0, "R11 idle channel stayed low", hiCnt[1], 0);
    clrCounts();
    setW(0, 9); setW(1, 3); step(2);
    trigRise = 2'b11; step(25);
    chk(hiCnt[0] == 9, "R11 channel 0 width", hiCnt[0], 9);
    chk(hiCnt[1] == 3, "R11 channel 1 width", hiCnt[1], 3);
    trigRise = 2'b00; step(6);

    // random phase against the model
    for (int k = 0; k < 5000; k++) begin
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(0, 5) == 0) trigRise[c] = ~trigRise[c];
        if ($urandom_range(0, 5) == 0) trigFall[c] = ~trigFall[c];
        if (clrN[c]) begin
          if ($urandom_range(0, 59) == 0) clrN[c] = 1'b0;
        end else if ($urandom_range(0, 3) == 0) clrN[c] = 1'b1;
        if (q[c] == 1'b0 && $urandom_range(0, 29) == 0) begin
          setW(c, $urandom_range(0, 12));
          retrigMode[c] = 1'($urandom_range(0, 1));
        end
      end
      step(1);
    end

    summary();
  end
endmodule